// File: doc/BRIEF.md
# Clock Ratio and Speed Detector

This block watches an audio stream's word-select signal and the ticks of its system clock. It reports how many system-clock ticks make up one sample period, and which of nine legal ratios that count is. It also sorts the stream into a single-speed band, a double-speed band or an unsupported rate. The sample rate is taken from the word-select period measured in cycles of a reference clock of known frequency (`REF_HZ`). Because of this, the speed decision does not depend on the system clock being a standard audio frequency. A master clock such as 25 MHz or 26 MHz is classified correctly.

All inputs are synchronous to the reference clock. Upstream logic supplies `mclk_tick`, a one-cycle strobe for each system-clock rising edge, and `ws_level`, the synchronised word-select level. A period runs from one word-select rising edge to the next, and it is judged when its closing edge arrives.

A four-state machine governs the outputs:

- **LOST**: no clock. The first rising edge moves it to ALIGN (transition *acquire*).
- **ALIGN**: waits for the first complete period. The next edge moves it to HUNT, or to LOCK if the run target is met (transition *first-measure*).
- **HUNT**: counts consecutive identical legal results. It goes to LOCK when the count reaches 4 (transition *qualify*).
- **LOCK**: any differing or illegal result returns it to HUNT (transition *break*).

From ALIGN, HUNT or LOCK, a timeout returns the machine to LOST (transition *expire*).

Top module: `clk_ratio_detect`

## Requirements
- R1: After reset, `clk_lost`=1, `locked`=0, `ratio_code`=15 and `speed_mode`=0.
- R2: A judged period's tick count selects a ratio code when it lies within ±1 of a nominal ratio. The codes are 0:32, 1:64, 2:128, 3:192, 4:256, 5:384, 6:512, 7:768 and 8:1024. The value 15 means no legal ratio.
- R3: The period P, in reference cycles, sets `speed_mode`. With the default 64 MHz reference, 1 (single) applies when REF_HZ/50000 ≤ P ≤ REF_HZ/8000, which is 1280 to 8000. 2 (double) applies when REF_HZ/100000 ≤ P ≤ ceil(REF_HZ/84000), which is 640 to 762. Every other period gives 0 (unsupported).
- R4: Ratios 32 and 64 are illegal at double speed. Any ratio is illegal at unsupported speed. An illegal period gives `ratio_code`=15 and never leads to lock.
- R5: `locked` rises after four consecutive judged periods give the same legal code and speed. The first period after leaving LOST counts as one of the four.
- R6: A single illegal period in LOCK clears `locked` at the edge that closes it.
- R7: If no rising edge arrives for P8+P8/8 reference cycles (9000 by default), `clk_lost`=1, `locked`=0, `ratio_code`=15 and `speed_mode`=0. The next edge clears `clk_lost`.
- R8: `ratio_code` changes only in the cycle after a word-select rising edge or on entry to LOST.
- R9: `locked` and `clk_lost` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of frequency REF_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_tick | input | 1 | One-cycle strobe per system-clock rising edge |
| ws_level | input | 1 | Synchronised word-select level |
| ratio_code | output | 4 | Detected ratio code, 15 when none |
| speed_mode | output | 2 | 0 unsupported, 1 single, 2 double |
| locked | output | 1 | Ratio stable over four periods |
| clk_lost | output | 1 | Word-select edges missing |

## Verification
The stimulus is built from pairs of a period length and a tick spacing.

- Exact ratios in both bands show that the code lookup works across the whole list.
- Counts one and two ticks away from 256 separate the tolerance edge from a miss.
- Ratio 64 at double speed isolates the per-mode legality mask.
- A 768-cycle period falls in the gap between the bands and must give unsupported.
- Periods at exactly 50 kHz and 8 kHz probe the inclusive band limits.

Directed sequences then cover three further cases:

- an illegal period that breaks lock;
- word-select held quiet on both sides of the timeout;
- recovery after the clock is lost.

// File: rtl/crsd_pkg.sv
`timescale 1ns/1ps
package crsd_pkg;
    localparam int N_RATIO = 9;
    localparam logic [3:0] CODE_NONE = 4'hF;
    localparam logic [1:0] SPD_NONE   = 2'd0;
    localparam logic [1:0] SPD_SINGLE = 2'd1;
    localparam logic [1:0] SPD_DOUBLE = 2'd2;
    localparam int DOUBLE_MIN_CODE = 2;

    typedef enum logic [1:0] {ST_LOST, ST_ALIGN, ST_HUNT, ST_LOCK} det_state_t;

    function automatic int ratio_nominal(input int idx);
        case (idx)
            0:       return 32;
            1:       return 64;
            2:       return 128;
            3:       return 192;
            4:       return 256;
            5:       return 384;
            6:       return 512;
            7:       return 768;
            default: return 1024;
        endcase
    endfunction
endpackage

// File: rtl/crsd_period_meter.sv
`timescale 1ns/1ps
module crsd_period_meter #(
    parameter int REF_W  = 14,
    parameter int TICK_W = 12,
    parameter int TMO    = 9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ws,
    output logic              edge_o,
    output logic [REF_W-1:0]  period_o,
    output logic [TICK_W-1:0] ticks_o,
    output logic              timeout_o
);
    localparam logic [REF_W-1:0]  TMO_C    = REF_W'(TMO);
    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    logic ws_q;

    assign edge_o    = ws & ~ws_q;
    assign timeout_o = ~edge_o && (period_o == TMO_C - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q     <= 1'b1;
            period_o <= TMO_C;
            ticks_o  <= '0;
        end else begin
            ws_q <= ws;
            if (edge_o) begin
                period_o <= REF_W'(1);
                ticks_o  <= tick ? TICK_W'(1) : '0;
            end else begin
                if (period_o != TMO_C)
                    period_o <= period_o + 1'b1;
                if (tick && ticks_o != TICK_MAX)
                    ticks_o <= ticks_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/crsd_rate_class.sv
`timescale 1ns/1ps
module crsd_rate_class
    import crsd_pkg::*;
#(
    parameter int REF_W  = 14,
    parameter int REF_HZ = 64_000_000
) (
    input  logic [REF_W-1:0] period,
    output logic [1:0]       speed
);
    localparam logic [REF_W-1:0] P_SLOW_MAX = REF_W'(REF_HZ / 8000);
    localparam logic [REF_W-1:0] P_SLOW_MIN = REF_W'(REF_HZ / 50000);
    localparam logic [REF_W-1:0] P_FAST_MAX = REF_W'((REF_HZ + 83999) / 84000);
    localparam logic [REF_W-1:0] P_FAST_MIN = REF_W'(REF_HZ / 100000);

    always_comb begin
        if (period >= P_SLOW_MIN && period <= P_SLOW_MAX)
            speed = SPD_SINGLE;
        else if (period >= P_FAST_MIN && period <= P_FAST_MAX)
            speed = SPD_DOUBLE;
        else
            speed = SPD_NONE;
    end
endmodule

// File: rtl/crsd_ratio_match.sv
`timescale 1ns/1ps
module crsd_ratio_match
    import crsd_pkg::*;
#(
    parameter int TICK_W = 12,
    parameter int TOL    = 1
) (
    input  logic [TICK_W-1:0] ticks,
    input  logic [1:0]        speed,
    output logic [3:0]        code,
    output logic              legal
);
    localparam logic [TICK_W:0] TOL_C = (TICK_W+1)'(TOL);

    logic [TICK_W:0]    tx;
    logic [N_RATIO-1:0] hit;

    assign tx = {1'b0, ticks};

    for (genvar i = 0; i < N_RATIO; i++) begin : g_cmp
        localparam logic [TICK_W:0] NOM = (TICK_W+1)'(ratio_nominal(i));
        assign hit[i] = (tx + TOL_C >= NOM) && (tx <= NOM + TOL_C);
    end

    always_comb begin
        code = CODE_NONE;
        for (int i = N_RATIO - 1; i >= 0; i--)
            if (hit[i]) code = 4'(i);
    end

    always_comb begin
        legal = 1'b0;
        if (code != CODE_NONE) begin
            if (speed == SPD_SINGLE)
                legal = 1'b1;
            else if (speed == SPD_DOUBLE)
                legal = (code >= 4'(DOUBLE_MIN_CODE));
        end
    end
endmodule

// File: rtl/clk_ratio_detect.sv
`timescale 1ns/1ps
module clk_ratio_detect
    import crsd_pkg::*;
#(
    parameter int REF_HZ   = 64_000_000,
    parameter int TICK_W   = 12,
    parameter int TOL      = 1,
    parameter int LOCK_RUN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_tick,
    input  logic       ws_level,
    output logic [3:0] ratio_code,
    output logic [1:0] speed_mode,
    output logic       locked,
    output logic       clk_lost
);
    localparam int P_SLOW = REF_HZ / 8000;
    localparam int TMO    = P_SLOW + P_SLOW / 8;
    localparam int REF_W  = $clog2(TMO + 1);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_TGT = RUN_W'(LOCK_RUN);

    logic              ws_edge, tmo;
    logic [REF_W-1:0]  period;
    logic [TICK_W-1:0] ticks;
    logic [1:0]        meas_speed;
    logic [3:0]        meas_code;
    logic              meas_legal, same;
    det_state_t        st, st_nxt;
    logic [RUN_W-1:0]  run, run_nxt;

    crsd_period_meter #(.REF_W(REF_W), .TICK_W(TICK_W), .TMO(TMO)) u_meter (
        .clk(clk), .rst_n(rst_n), .tick(mclk_tick), .ws(ws_level),
        .edge_o(ws_edge), .period_o(period), .ticks_o(ticks), .timeout_o(tmo)
    );

    crsd_rate_class #(.REF_W(REF_W), .REF_HZ(REF_HZ)) u_class (
        .period(period), .speed(meas_speed)
    );

    crsd_ratio_match #(.TICK_W(TICK_W), .TOL(TOL)) u_match (
        .ticks(ticks), .speed(meas_speed), .code(meas_code), .legal(meas_legal)
    );

    assign same = (meas_code == ratio_code) && (meas_speed == speed_mode);

    // next-state logic
    always_comb begin
        st_nxt  = st;
        run_nxt = run;
        unique case (st)
            ST_LOST: begin
                run_nxt = '0;
                if (ws_edge) st_nxt = ST_ALIGN;            // acquire
            end
            ST_ALIGN, ST_HUNT, ST_LOCK: begin
                if (tmo) begin                              // expire
                    st_nxt  = ST_LOST;
                    run_nxt = '0;
                end else if (ws_edge) begin
                    if (!meas_legal)
                        run_nxt = '0;
                    else if (!same)
                        run_nxt = RUN_W'(1);
                    else if (run < RUN_TGT)
                        run_nxt = run + 1'b1;
                    // qualify / first-measure / break
                    st_nxt = (run_nxt >= RUN_TGT) ? ST_LOCK : ST_HUNT;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_LOST;
            run <= '0;
        end else begin
            st  <= st_nxt;
            run <= run_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_code <= CODE_NONE;
            speed_mode <= SPD_NONE;
        end else if (st != ST_LOST && tmo) begin
            ratio_code <= CODE_NONE;
            speed_mode <= SPD_NONE;
        end else if (st != ST_LOST && ws_edge) begin
            ratio_code <= meas_legal ? meas_code : CODE_NONE;
            speed_mode <= meas_speed;
        end
    end

    assign locked   = (st == ST_LOCK);
    assign clk_lost = (st == ST_LOST);
endmodule

// File: rtl/crsd_checker.sv
`timescale 1ns/1ps
module crsd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ws_level,
    input logic [3:0] ratio_code,
    input logic [1:0] speed_mode,
    input logic       locked,
    input logic       clk_lost
);
    AST_LOCK_LOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && clk_lost)); // R9

    AST_LOCK_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ratio_code != 4'hF); // R4

    AST_DOUBLE_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_mode == 2'd2 && ratio_code != 4'hF) |-> ratio_code >= 4'd2); // R4

    AST_LOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lost |-> (ratio_code == 4'hF && speed_mode == 2'd0 && !locked)); // R7

    AST_LOCK_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(ws_level) && !$past(ws_level, 2))); // R5

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!($past(ws_level) && !$past(ws_level, 2)) && !clk_lost) |-> $stable(ratio_code)); // R8
endmodule

bind clk_ratio_detect crsd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ws_level(ws_level), .ratio_code(ratio_code),
    .speed_mode(speed_mode), .locked(locked), .clk_lost(clk_lost)
);

// File: tb/clk_ratio_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_tick = 1'b0;
    logic ws_level = 1'b0;
    logic [3:0] ratio_code;
    logic [1:0] speed_mode;
    logic locked, clk_lost;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clk_ratio_detect u_dut (
        .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .ws_level(ws_level),
        .ratio_code(ratio_code), .speed_mode(speed_mode),
        .locked(locked), .clk_lost(clk_lost)
    );

    localparam int NV = 12;
    localparam int VPER [NV] = '{1280, 640, 640, 1600, 2048, 768, 2000, 1344, 1536, 1285, 1290, 8000};
    localparam int VSPC [NV] = '{5,    5,   10,  50,   2,    2,   20,   7,    3,    5,    5,    250};
    localparam int NOMS [9]  = '{32, 64, 128, 192, 256, 384, 512, 768, 1024};

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic run_periods(input int per, input int spc, input int n);
        for (int k = 0; k < n; k++)
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                ws_level  = (c < per / 2);
                mclk_tick = ((c % spc) == 0);
            end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ws_level  = 1'b0;
            mclk_tick = 1'b1;
        end
    endtask

    // reference model from R2, R3, R4
    task automatic model(input int per, input int spc, output int code, output int spd, output int lk);
        int t;
        t = (per + spc - 1) / spc;
        if (per >= 1280 && per <= 8000) spd = 1;
        else if (per >= 640 && per <= 762) spd = 2;
        else spd = 0;
        code = 15;
        for (int i = 0; i < 9; i++)
            if (t >= NOMS[i] - 1 && t <= NOMS[i] + 1) code = i;
        if (spd == 0 || (spd == 2 && code < 2)) code = 15;
        lk = (code != 15) ? 1 : 0;
    endtask

    initial begin
        int ec, es, el;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lost", clk_lost, 1);
        check("R1 locked", locked, 0);
        check("R1 code", ratio_code, 15);
        check("R1 speed", speed_mode, 0);

        // table walk: R2 codes, R3 bands, R4 legality, R5 lock
        for (int v = 0; v < NV; v++) begin
            run_periods(VPER[v], VSPC[v], 5);
            model(VPER[v], VSPC[v], ec, es, el);
            check("R2/R4 code", ratio_code, ec);
            check("R3 speed", speed_mode, es);
            check("R5 locked", locked, el);
        end

        // R6: one bad period breaks lock
        run_periods(1280, 5, 5);
        check("R5 relock", locked, 1);
        run_periods(1290, 5, 1);
        run_periods(1280, 5, 1);
        check("R6 locked", locked, 0);
        check("R6 code", ratio_code, 15);

        // R7: timeout
        idle(7000);
        check("R7 not yet lost", clk_lost, 0);
        idle(1000);
        check("R7 lost", clk_lost, 1);
        check("R7 locked", locked, 0);
        check("R7 code", ratio_code, 15);
        check("R7 speed", speed_mode, 0);

        // R7 recovery
        run_periods(1280, 5, 5);
        check("R7 recovered", clk_lost, 0);
        check("R5 lock after loss", locked, 1);
        check("R2 code after loss", ratio_code, 4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule